// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shifter

This block turns a parallel word into a serial bit stream, one bit per shift event, with the last stage driven out in both true and inverted form. It runs on one free-running system clock. Two slow strobe inputs are combined by OR into a gated shift clock. A rising edge of that combined level, while the load control is inactive, advances the register by one stage toward the output. A new bit from the serial input enters the first stage.

An active-low load control overrides everything else. While it is low, the register copies the parallel inputs on every system cycle. Edges seen on the strobes during that time are dropped. The strobes, the load control and the serial input all pass through a two-flop synchroniser first. Any input change therefore takes effect at the third rising system-clock edge after it is applied.

Top module: `piso_gated_shifter`

## Requirements
- R1: A synchronous active-high reset clears every stage, so q_out is 0 and q_out_n is 1 after reset. The synchronised load control comes out of reset inactive.
- R2: While load_n is low, each stage i takes par_in[i] on every system cycle, whatever tick_a, tick_b and ser_in do. par_in[0] feeds the first stage and par_in[WIDTH-1] feeds the output stage.
- R3: A rising edge on tick_a while tick_b is low and load_n is high shifts the register once. Stage i takes stage i-1, and stage 0 takes ser_in.
- R4: A rising edge on tick_b while tick_a is low also shifts once, exactly as in R3.
- R5: While either tick input is held high, toggling the other one leaves the register unchanged.
- R6: After a load, q_out first shows par_in[WIDTH-1]. After WIDTH-1 further shifts it shows par_in[0].
- R7: q_out_n is always the inverse of q_out.
- R8: A load asserted in the middle of a shift sequence takes over at once. Strobe edges while load_n is low cause no shift. Releasing load_n with both strobes low changes nothing.
- R9: A change on tick_a, tick_b, ser_in or load_n shows at the outputs only after the third rising system-clock edge following it.
- R10: A falling edge of the combined strobe level causes no shift. No two consecutive system cycles both carry a shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | WIDTH | Parallel load word; bit 0 goes to the first stage |
| load_n | input | 1 | Load control, active low, level sensitive |
| tick_a | input | 1 | Shift strobe, combined by OR with tick_b |
| tick_b | input | 1 | Shift strobe, interchangeable with tick_a |
| ser_in | input | 1 | Serial bit entering stage 0 on a shift |
| q_out | output | 1 | Output stage value |
| q_out_n | output | 1 | Inverse of the output stage |

## Verification
The bench drives shifts from each strobe in turn and holds one strobe high while toggling the other. A design that did not OR the strobes would miss the shifts from tick_b or shift during an inhibit. It checks that falling strobe edges do nothing, which catches an edge detector that fires on any change. It asserts a load in the middle of a shift sequence while a strobe rises, which exposes a design that gives the shift priority. It also samples the output one cycle before and exactly at the expected latency, which catches a missing or extra synchroniser stage.

// File: rtl/piso_pkg.sv
package piso_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } op_e;

    typedef struct packed {
        logic load_n;
        logic tick_a;
        logic tick_b;
        logic ser;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{load_n: 1'b1, tick_a: 1'b0, tick_b: 1'b0, ser: 1'b0};

    function automatic op_e pick_op(input logic load_act, input logic rise);
        if (load_act)  return OP_LOAD;
        else if (rise) return OP_SHIFT;
        else           return OP_HOLD;
    endfunction

endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/piso_edge_detect.sv
module piso_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic tick_a,
    input  logic tick_b,
    output logic rise
);
    logic level_now;
    logic level_prev;

    assign level_now = tick_a | tick_b;

    always_ff @(posedge clk) begin
        if (rst) level_prev <= 1'b0;
        else     level_prev <= level_now;
    end

    assign rise = level_now & ~level_prev;
endmodule

// File: rtl/piso_stage_chain.sv
module piso_stage_chain
    import piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stages
);
    logic [WIDTH-1:0] shifted;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign shifted[i] = ser_in;
        end else begin : g_rest
            assign shifted[i] = stages[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stages <= '0;
        end else begin
            unique case (op)
                OP_LOAD:  stages <= par_in;
                OP_SHIFT: stages <= shifted;
                default:  stages <= stages;
            endcase
        end
    end
endmodule

// File: rtl/piso_gated_shifter.sv
module piso_gated_shifter
    import piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] par_in,
    input  logic             load_n,
    input  logic             tick_a,
    input  logic             tick_b,
    input  logic             ser_in,
    output logic             q_out,
    output logic             q_out_n
);
    localparam int CTL_W = $bits(ctl_t);

    ctl_t             ctl_raw;
    ctl_t             ctl_s;
    logic             rise;
    logic             load_act;
    logic             shift_ev;
    logic             ser_s;
    op_e              op;
    logic [WIDTH-1:0] stages;

    assign ctl_raw = '{load_n: load_n, tick_a: tick_a, tick_b: tick_b, ser: ser_in};

    piso_sync #(.W(CTL_W), .RST_VAL(CTL_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    piso_edge_detect u_edge (
        .clk    (clk),
        .rst    (rst),
        .tick_a (ctl_s.tick_a),
        .tick_b (ctl_s.tick_b),
        .rise   (rise)
    );

    assign load_act = ~ctl_s.load_n;
    assign shift_ev = rise & ~load_act;
    assign ser_s    = ctl_s.ser;
    assign op       = pick_op(load_act, rise);

    piso_stage_chain #(.WIDTH(WIDTH)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .par_in (par_in),
        .ser_in (ser_s),
        .stages (stages)
    );

    assign q_out   = stages[WIDTH-1];
    assign q_out_n = ~stages[WIDTH-1];
endmodule

// File: rtl/piso_gated_shifter_chk.sv
module piso_gated_shifter_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] par_in,
    input logic             load_act,
    input logic             shift_ev,
    input logic             ser_s,
    input logic [WIDTH-1:0] stages,
    input logic             q_out,
    input logic             q_out_n
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (stages == '0)); // R1

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        load_act |=> (stages == $past(par_in))); // R2

    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
        shift_ev |=> (stages == {$past(stages[WIDTH-2:0]), $past(ser_s)})); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!shift_ev && !load_act) |=> $stable(stages)); // R5

    AST_OUT_PAIR: assert property (@(posedge clk) disable iff (rst)
        q_out != q_out_n); // R7

    AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (rst)
        shift_ev |=> !shift_ev); // R10
endmodule

bind piso_gated_shifter piso_gated_shifter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .par_in   (par_in),
    .load_act (load_act),
    .shift_ev (shift_ev),
    .ser_s    (ser_s),
    .stages   (stages),
    .q_out    (q_out),
    .q_out_n  (q_out_n)
);

// File: tb/piso_gated_shifter_bench.sv
module piso_gated_shifter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 8;
    localparam int NVEC       = 13;

    // each vector: {load_n, tick_a, tick_b, ser_in, expected q_out}; par_in = 8'hB2
    localparam logic [4:0] VEC [NVEC] = '{
        5'b0_0_0_0_1, // load, q = par[7]
        5'b1_0_0_0_1, // release load, no change
        5'b1_1_0_1_0, // tick_a rise, shift in 1
        5'b1_0_0_1_0, // tick_a fall, no shift
        5'b1_1_0_0_1, // tick_a rise, shift in 0
        5'b1_0_0_0_1, // fall
        5'b1_0_1_1_1, // tick_b rise, shift in 1
        5'b1_0_0_0_1, // fall
        5'b1_0_1_0_0, // tick_b rise, shift in 0
        5'b1_1_1_1_0, // tick_b held high, tick_a rises: hold
        5'b1_0_1_1_0, // hold
        5'b1_1_1_1_0, // hold
        5'b1_0_0_1_0  // both fall: hold
    };

    logic             clk = 1'b0;
    logic             rst;
    logic [WIDTH-1:0] par_in;
    logic             load_n, tick_a, tick_b, ser_in;
    logic             q_out, q_out_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    piso_gated_shifter #(.WIDTH(WIDTH)) u_piso_gated_shifter (
        .clk(clk), .rst(rst), .par_in(par_in), .load_n(load_n),
        .tick_a(tick_a), .tick_b(tick_b), .ser_in(ser_in),
        .q_out(q_out), .q_out_n(q_out_n)
    );

    task automatic check(input logic exp, input string req);
        checks++;
        if (q_out !== exp) begin
            fails++;
            $display("FAIL %s: q_out=%b expected %b", req, q_out, exp);
        end
        checks++;
        if (q_out_n !== ~exp) begin
            fails++;
            $display("FAIL R7 (%s): q_out_n=%b expected %b", req, q_out_n, ~exp);
        end
    endtask

    task automatic drive(input logic ld, input logic ta, input logic tb, input logic s);
        @(negedge clk);
        load_n = ld; tick_a = ta; tick_b = tb; ser_in = s;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            report();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; par_in = 8'hB2; load_n = 1'b1;
        tick_a = 1'b0; tick_b = 1'b0; ser_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1'b0, "R1 reset state");
        rst = 1'b0;

        // vector table: R2 R3 R4 R5 R10
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
            check(VEC[i][0], $sformatf("R2/R3/R4/R5/R10 vector %0d", i));
        end

        // R6: loaded word leaves last stage first, first stage after WIDTH-1 shifts
        par_in = 8'b0110_1001;
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        check(par_in[WIDTH-1], "R6 first bit");
        for (int k = 1; k < WIDTH; k++) begin
            drive(1'b1, 1'b1, 1'b0, 1'b0);
            drive(1'b1, 1'b0, 1'b0, 1'b0);
            check(par_in[WIDTH-1-k], $sformatf("R6 shift %0d", k));
        end
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        check(1'b0, "R3 serial zero reaches output");

        // R8: load mid-sequence overrides, strobe edges during load ignored
        par_in = 8'hFF;
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        par_in = 8'b1100_0000;
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        check(1'b1, "R8 load overrides rising strobe");
        drive(1'b0, 1'b0, 1'b1, 1'b0);
        check(1'b1, "R8 strobe edge during load");
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        check(1'b1, "R8 release load without edge");
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        check(1'b1, "R8 first shift after load gives par[6]");
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        check(1'b0, "R8 second shift gives par[5]");

        // R9: latency of three system edges
        par_in = 8'b1000_0000;
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        check(1'b1, "R9 setup");
        @(negedge clk);
        tick_a = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(1'b1, "R9 no change after two edges");
        @(posedge clk);
        @(negedge clk);
        check(1'b0, "R9 change after third edge");
        drive(1'b1, 1'b0, 1'b0, 1'b0);

        // R1: reset in mid-run clears stages
        par_in = 8'hFF;
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        check(1'b1, "R1 setup");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(1'b0, "R1 mid-run reset");
        rst = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(1'b0, "R1 no reload after reset");

        done = 1'b1;
        report();
        $finish;
    end
endmodule